// File: doc/BRIEF.md
# Shadow-Stack-Aware Leaf Permission Checker

This block sits right after a first-stage page-table walk has found its leaf entry. It takes the leaf's read, write and execute bits, the user bit, and the context of the access. From these it decides whether the access is granted. The context covers the access type, the privilege, the shadow-stack marker, the misalignment flag and the make-executable-readable and supervisor-user-access controls. When the access is not granted, the block gives the exception cause that the core should raise.

The entry with write set and read and execute clear is normally a reserved encoding. When shadow-stack protection is enabled and the walk is first-stage, that entry marks a shadow-stack page. Such a page can be written only by shadow-stack accesses, and ordinary code may only read it. A denied access to such a page is reported as an access fault, not as a page fault.

A request is presented with a one-cycle strobe. The response appears one cycle later and is held until the next request. The context index holds three fields: the privilege in its two low bits, a two-stage marker in bit 2, and the shadow-stack marker in bit 3.

Top module: `shstk_perm_chk`

## Requirements
- R1: After reset, rsp_valid_o, grant_o, fault_o, cause_o and the effective permission outputs are all 0. rsp_valid_o is 1 exactly in the cycle after req_valid_i was 1. The result outputs change only in that cycle and hold their values otherwise.
- R2: A leaf with R=0, W=1, X=1 is always reserved. The response is a page fault (load 13, store 15, fetch 12) with effective permissions 000.
- R3: A leaf with R=0, W=1, X=0 is reserved and gives a page fault with effective permissions 000, unless shadow-stack enable is 1 and the walk counts as first-stage. A walk counts as first-stage when first_stage_i is 1, or when context bit 2 is 0 (single-stage translation).
- R4: Otherwise that leaf is a shadow-stack page. Its effective permissions are R=1, W=1, X=0 for an access whose context bit 3 is 1, and R=1, W=0, X=0 for any other access.
- R5: A store whose context bit 3 is 1, to a leaf with R=1, W=0, X=0, raises a store page fault (15).
- R6: An access denied by the permission check on a shadow-stack page raises an access fault: load 5, store 7, fetch 1.
- R7: An access denied by the permission check on any other page raises a page fault: load 13, store 15, fetch 12.
- R8: Misalignment is checked first and takes priority over every other check. A misaligned load or store with context bit 3 set raises access fault 5 or 7. Without that bit, the causes are 4 (load), 6 (store) and 0 (fetch).
- R9: Access type 0 is load, 1 is store, and 2 or 3 is fetch. A load tests the effective R bit, a store the W bit and a fetch the X bit. The effective R bit is also set when mxr_i is 1 and X is 1.
- R10: Context bits [1:0] give the privilege: 0 is user, 1 is supervisor, 2 is supervisor with SUM forced, and 3 is treated as supervisor. A user access to a leaf with U=0 is a page fault. A supervisor fetch from a leaf with U=1 is a page fault. A supervisor load or store to a leaf with U=1 is a page fault unless SUM is in effect.
- R11: In every response exactly one of grant_o and fault_o is 1, and a granted response carries cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| pte_r_i | input | 1 | Leaf read bit |
| pte_w_i | input | 1 | Leaf write bit |
| pte_x_i | input | 1 | Leaf execute bit |
| pte_u_i | input | 1 | Leaf user bit |
| ss_en_i | input | 1 | Shadow-stack protection enabled |
| first_stage_i | input | 1 | Walk is the first stage of a two-stage walk |
| ctx_idx_i | input | 4 | Context: [1:0] privilege, [2] two-stage, [3] shadow-stack access |
| acc_type_i | input | 2 | 0 load, 1 store, 2/3 fetch |
| misalign_i | input | 1 | Access address misaligned |
| mxr_i | input | 1 | Executable pages readable |
| sum_i | input | 1 | Supervisor may touch user pages |
| rsp_valid_o | output | 1 | Response strobe |
| eff_r_o | output | 1 | Effective read permission |
| eff_w_o | output | 1 | Effective write permission |
| eff_x_o | output | 1 | Effective execute permission |
| grant_o | output | 1 | Access granted |
| fault_o | output | 1 | Access faults |
| cause_o | output | 5 | Exception cause, 0 when granted |

## Verification
The bench tries every combination of the leaf bits, the enable, the stage flag and the two-stage bit. It crosses these with the shadow-stack marker, all three access types, the misalignment flag, all four privilege codes, the U bit, MXR and SUM. It compares each response with an arithmetic model.

The eight leaf encodings separate the two reserved encodings from the readable ones. The enable, stage and marker combinations separate a shadow-stack page from a reserved one, and a shadow-stack access from an ordinary one. The access types and the misalignment flag separate access faults from page faults from misaligned causes. Between requests the inputs are inverted, which shows that the held result ignores them.

// File: rtl/shstk_pkg.sv
package shstk_pkg;

  localparam int CAUSE_W = 5;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_FALT  = 2'd3
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rwx_t;

  localparam logic [CAUSE_W-1:0] EXC_FETCH_MISAL = 5'd0;
  localparam logic [CAUSE_W-1:0] EXC_FETCH_AF    = 5'd1;
  localparam logic [CAUSE_W-1:0] EXC_LOAD_MISAL  = 5'd4;
  localparam logic [CAUSE_W-1:0] EXC_LOAD_AF     = 5'd5;
  localparam logic [CAUSE_W-1:0] EXC_STORE_MISAL = 5'd6;
  localparam logic [CAUSE_W-1:0] EXC_STORE_AF    = 5'd7;
  localparam logic [CAUSE_W-1:0] EXC_FETCH_PF    = 5'd12;
  localparam logic [CAUSE_W-1:0] EXC_LOAD_PF     = 5'd13;
  localparam logic [CAUSE_W-1:0] EXC_STORE_PF    = 5'd15;

  function automatic logic [CAUSE_W-1:0] pf_cause(acc_e a);
    case (a)
      ACC_LOAD:  return EXC_LOAD_PF;
      ACC_STORE: return EXC_STORE_PF;
      default:   return EXC_FETCH_PF;
    endcase
  endfunction

  function automatic logic [CAUSE_W-1:0] af_cause(acc_e a);
    case (a)
      ACC_LOAD:  return EXC_LOAD_AF;
      ACC_STORE: return EXC_STORE_AF;
      default:   return EXC_FETCH_AF;
    endcase
  endfunction

  // shadow-stack data accesses turn misalignment into access faults
  function automatic logic [CAUSE_W-1:0] misal_cause(acc_e a, logic ss);
    case (a)
      ACC_LOAD:  return ss ? EXC_LOAD_AF : EXC_LOAD_MISAL;
      ACC_STORE: return ss ? EXC_STORE_AF : EXC_STORE_MISAL;
      default:   return EXC_FETCH_MISAL;
    endcase
  endfunction

endpackage

// File: rtl/shstk_pte_class.sv
module shstk_pte_class
  import shstk_pkg::*;
#(
  parameter bit SS_SUPPORT = 1'b1
) (
  input  rwx_t pte_i,
  input  logic ss_en_i,
  input  logic first_eff_i,
  input  logic ss_acc_i,
  input  logic mxr_i,
  output logic rsv_o,
  output logic ss_page_o,
  output rwx_t eff_o
);

  logic ss_cand;
  logic w_only;
  logic w_x;

  generate
    if (SS_SUPPORT) begin : g_ss
      assign ss_cand = ss_en_i & first_eff_i;
    end else begin : g_no_ss
      logic unused_ss;
      assign unused_ss = ss_en_i & first_eff_i;
      assign ss_cand   = 1'b0 & unused_ss;
    end
  endgenerate

  assign w_only    = ~pte_i.r & pte_i.w & ~pte_i.x;
  assign w_x       = ~pte_i.r & pte_i.w & pte_i.x;
  assign ss_page_o = w_only & ss_cand;
  assign rsv_o     = w_x | (w_only & ~ss_cand);

  always_comb begin
    eff_o = '0;
    if (rsv_o) begin
      eff_o = '0;
    end else if (ss_page_o) begin
      eff_o.r = 1'b1;
      eff_o.w = ss_acc_i;
      eff_o.x = 1'b0;
    end else begin
      eff_o.r = pte_i.r | (pte_i.x & mxr_i);
      eff_o.w = pte_i.w;
      eff_o.x = pte_i.x;
    end
  end

endmodule

// File: rtl/shstk_fault_sel.sv
module shstk_fault_sel
  import shstk_pkg::*;
(
  input  acc_e               acc_i,
  input  logic               misal_i,
  input  logic               ss_acc_i,
  input  logic               rsv_i,
  input  logic               ss_page_i,
  input  rwx_t               pte_i,
  input  rwx_t               eff_i,
  input  logic               priv_s_i,
  input  logic               pte_u_i,
  input  logic               sum_i,
  output logic               grant_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic is_load;
  logic is_store;
  logic sel_perm;
  logic ss_ro_store;
  logic priv_fail;

  assign is_load  = (acc_i == ACC_LOAD);
  assign is_store = (acc_i == ACC_STORE);

  always_comb begin
    if (is_load)       sel_perm = eff_i.r;
    else if (is_store) sel_perm = eff_i.w;
    else               sel_perm = eff_i.x;
  end

  assign ss_ro_store = ss_acc_i & is_store & pte_i.r & ~pte_i.w & ~pte_i.x;

  always_comb begin
    if (!priv_s_i) priv_fail = ~pte_u_i;
    else           priv_fail = pte_u_i & ((~is_load & ~is_store) | ~sum_i);
  end

  always_comb begin
    grant_o = 1'b0;
    fault_o = 1'b1;
    cause_o = pf_cause(acc_i);
    if (misal_i) begin
      cause_o = misal_cause(acc_i, ss_acc_i);
    end else if (rsv_i || ss_ro_store || priv_fail) begin
      cause_o = pf_cause(acc_i);
    end else if (!sel_perm) begin
      cause_o = ss_page_i ? af_cause(acc_i) : pf_cause(acc_i);
    end else begin
      grant_o = 1'b1;
      fault_o = 1'b0;
      cause_o = '0;
    end
  end

endmodule

// File: rtl/shstk_perm_chk.sv
module shstk_perm_chk
  import shstk_pkg::*;
#(
  parameter int CTX_W      = 4,
  parameter int SS_BIT     = 3,
  parameter int STAGE_BIT  = 2,
  parameter bit SS_SUPPORT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               pte_r_i,
  input  logic               pte_w_i,
  input  logic               pte_x_i,
  input  logic               pte_u_i,
  input  logic               ss_en_i,
  input  logic               first_stage_i,
  input  logic [CTX_W-1:0]   ctx_idx_i,
  input  logic [1:0]         acc_type_i,
  input  logic               misalign_i,
  input  logic               mxr_i,
  input  logic               sum_i,
  output logic               rsp_valid_o,
  output logic               eff_r_o,
  output logic               eff_w_o,
  output logic               eff_x_o,
  output logic               grant_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_S_SUM = 2'd2;

  acc_e              acc;
  rwx_t              pte;
  rwx_t              eff;
  logic              ss_acc;
  logic              first_eff;
  logic [PRIV_W-1:0] priv_lo;
  logic              priv_s;
  logic              sum_eff;
  logic              rsv;
  logic              ss_page;
  logic              grant_d;
  logic              fault_d;
  logic [CAUSE_W-1:0] cause_d;

  assign acc       = acc_e'(acc_type_i);
  assign pte       = '{r: pte_r_i, w: pte_w_i, x: pte_x_i};
  assign ss_acc    = ctx_idx_i[SS_BIT];
  // single-stage context: every walk is first-stage
  assign first_eff = first_stage_i | ~ctx_idx_i[STAGE_BIT];
  assign priv_lo   = ctx_idx_i[PRIV_W-1:0];
  assign priv_s    = |priv_lo;
  assign sum_eff   = sum_i | (priv_lo == PRIV_S_SUM);

  shstk_pte_class #(
    .SS_SUPPORT (SS_SUPPORT)
  ) i_class (
    .pte_i       (pte),
    .ss_en_i     (ss_en_i),
    .first_eff_i (first_eff),
    .ss_acc_i    (ss_acc),
    .mxr_i       (mxr_i),
    .rsv_o       (rsv),
    .ss_page_o   (ss_page),
    .eff_o       (eff)
  );

  shstk_fault_sel i_sel (
    .acc_i     (acc),
    .misal_i   (misalign_i),
    .ss_acc_i  (ss_acc),
    .rsv_i     (rsv),
    .ss_page_i (ss_page),
    .pte_i     (pte),
    .eff_i     (eff),
    .priv_s_i  (priv_s),
    .pte_u_i   (pte_u_i),
    .sum_i     (sum_eff),
    .grant_o   (grant_d),
    .fault_o   (fault_d),
    .cause_o   (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      eff_r_o     <= 1'b0;
      eff_w_o     <= 1'b0;
      eff_x_o     <= 1'b0;
      grant_o     <= 1'b0;
      fault_o     <= 1'b0;
      cause_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        eff_r_o <= eff.r;
        eff_w_o <= eff.w;
        eff_x_o <= eff.x;
        grant_o <= grant_d;
        fault_o <= fault_d;
        cause_o <= cause_d;
      end
    end
  end

endmodule

// File: rtl/shstk_perm_chk_sva.sv
module shstk_perm_chk_sva #(
  parameter int CTX_W  = 4,
  parameter int SS_BIT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             pte_r_i,
  input logic             pte_w_i,
  input logic             pte_x_i,
  input logic [CTX_W-1:0] ctx_idx_i,
  input logic [1:0]       acc_type_i,
  input logic             misalign_i,
  input logic             rsp_valid_o,
  input logic             eff_r_o,
  input logic             eff_w_o,
  input logic             eff_x_o,
  input logic             grant_o,
  input logic             fault_o,
  input logic [4:0]       cause_o
);

  p_rsp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(cause_o) && $stable(grant_o) && $stable(fault_o)
                      && $stable({eff_r_o, eff_w_o, eff_x_o})));

  p_wx_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !misalign_i && !pte_r_i && pte_w_i && pte_x_i)
      |=> (fault_o && !grant_o && !eff_w_o && !eff_x_o));

  p_ss_ro_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !misalign_i && ctx_idx_i[SS_BIT] && acc_type_i == 2'd1
     && pte_r_i && !pte_w_i && !pte_x_i) |=> (cause_o == 5'd15));

  p_misal_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && misalign_i) |=> (fault_o && !grant_o));

  p_one_outcome_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({grant_o, fault_o}) == 1));

  p_grant_no_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (cause_o == 5'd0));

endmodule

bind shstk_perm_chk shstk_perm_chk_sva #(
  .CTX_W  (CTX_W),
  .SS_BIT (SS_BIT)
) i_shstk_perm_chk_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .pte_r_i     (pte_r_i),
  .pte_w_i     (pte_w_i),
  .pte_x_i     (pte_x_i),
  .ctx_idx_i   (ctx_idx_i),
  .acc_type_i  (acc_type_i),
  .misalign_i  (misalign_i),
  .rsp_valid_o (rsp_valid_o),
  .eff_r_o     (eff_r_o),
  .eff_w_o     (eff_w_o),
  .eff_x_o     (eff_x_o),
  .grant_o     (grant_o),
  .fault_o     (fault_o),
  .cause_o     (cause_o)
);

// File: tb/test_shstk_perm_chk.sv
module test_shstk_perm_chk;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       pte_r_i = 1'b0, pte_w_i = 1'b0, pte_x_i = 1'b0, pte_u_i = 1'b0;
  logic       ss_en_i = 1'b0, first_stage_i = 1'b0;
  logic [3:0] ctx_idx_i = '0;
  logic [1:0] acc_type_i = '0;
  logic       misalign_i = 1'b0, mxr_i = 1'b0, sum_i = 1'b0;
  logic       rsp_valid_o, eff_r_o, eff_w_o, eff_x_o, grant_o, fault_o;
  logic [4:0] cause_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  shstk_perm_chk i_shstk_perm_chk (
    .clk_i, .rst_ni, .req_valid_i, .pte_r_i, .pte_w_i, .pte_x_i, .pte_u_i,
    .ss_en_i, .first_stage_i, .ctx_idx_i, .acc_type_i, .misalign_i, .mxr_i,
    .sum_i, .rsp_valid_o, .eff_r_o, .eff_w_o, .eff_x_o, .grant_o, .fault_o,
    .cause_o
  );

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // result packing: {valid, r, w, x, grant, fault, cause[4:0]}
  function automatic logic [10:0] pack_out();
    return {rsp_valid_o, eff_r_o, eff_w_o, eff_x_o, grant_o, fault_o, cause_o};
  endfunction

  function automatic void model(
    input  logic r, w, x, u, en, first, ss, mis, mxr, sum,
    input  logic [1:0] priv, input logic two_stage, input int acc,
    output logic [10:0] exp, output string tag);
    logic ssp, rsv, er, ew, ex, sel, s_mode, sum_e, pfail;
    int pf, af, cause;
    bit g;
    ssp = !r && w && !x && en && (first || !two_stage);
    rsv = (!r && w && x) || (!r && w && !x && !ssp);
    if (rsv) begin er = 0; ew = 0; ex = 0; end
    else if (ssp) begin er = 1; ew = ss; ex = 0; end
    else begin er = r | (x & mxr); ew = w; ex = x; end
    pf = (acc == 0) ? 13 : (acc == 1) ? 15 : 12;
    af = (acc == 0) ? 5 : (acc == 1) ? 7 : 1;
    sel = (acc == 0) ? er : (acc == 1) ? ew : ex;
    s_mode = (priv != 2'd0);
    sum_e = sum || (priv == 2'd2);
    pfail = !s_mode ? !u : (u && (acc == 2 || !sum_e));
    g = 0;
    if (mis) begin
      tag = "R8";
      cause = (acc == 0) ? (ss ? 5 : 4) : (acc == 1) ? (ss ? 7 : 6) : 0;
    end else if (!r && w && x) begin
      tag = "R2"; cause = pf;
    end else if (rsv) begin
      tag = "R3"; cause = pf;
    end else if (ss && acc == 1 && r && !w && !x) begin
      tag = "R5"; cause = 15;
    end else if (pfail) begin
      tag = "R10"; cause = pf;
    end else if (!sel) begin
      tag = ssp ? "R6" : "R7"; cause = ssp ? af : pf;
    end else begin
      tag = ssp ? "R4" : "R9"; cause = 0; g = 1;
    end
    exp = {1'b1, er, ew, ex, g, !g, 5'(cause)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [10:0] exp, held;
    string tag;
    repeat (3) @(negedge clk_i);
    check("R1 reset", pack_out(), 11'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", pack_out(), 11'd0);
    for (int i = 0; i < 24576; i++) begin
      logic [12:0] b;
      int acc;
      b   = 13'(i % 8192);
      acc = i / 8192;
      {pte_r_i, pte_w_i, pte_x_i} = b[2:0];
      ss_en_i       = b[3];
      first_stage_i = b[4];
      misalign_i    = b[6];
      ctx_idx_i     = {b[5], b[9], b[8:7]};
      pte_u_i       = b[10];
      mxr_i         = b[11];
      sum_i         = b[12];
      acc_type_i    = 2'(acc);
      req_valid_i   = 1'b1;
      model(b[2], b[1], b[0], b[10], b[3], b[4], b[5], b[6], b[11], b[12],
            b[8:7], b[9], acc, exp, tag);
      @(negedge clk_i);
      check(tag, pack_out(), exp);
      if (grant_o == fault_o) check("R11", {grant_o, fault_o}, 11'b01);
      else n_chk++;
      held = {1'b0, exp[9:0]};
      // R1: inputs inverted while idle must leave the result untouched
      req_valid_i = 1'b0;
      {pte_r_i, pte_w_i, pte_x_i} = ~b[2:0];
      ss_en_i = ~b[3];
      first_stage_i = ~b[4];
      misalign_i = ~b[6];
      ctx_idx_i = ~ctx_idx_i;
      pte_u_i = ~b[10];
      mxr_i = ~b[11];
      sum_i = ~b[12];
      acc_type_i = 2'((acc + 1) % 3);
      @(negedge clk_i);
      check("R1 hold", pack_out(), held);
    end
    finish_run();
  end

endmodule